// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block turns a fast input clock into the timing a synchronous serial receiver needs. It divides the input clock by a programmable ratio to make a bit clock. A programmable down-counter counts those bit clocks to produce a periodic frame-sync pulse. The frame length is set on its own and does not depend on the word size. The pulse width and the sync polarity can both be programmed. Alongside the clock, the block gives a one-cycle strobe at the start of each bit period, so that logic in the input-clock domain can advance per bit without using the bit clock as a clock.

A small receive shifter is built in. After each frame sync it collects the first `WORD_W` serial bits, most significant bit first. It samples on the rising or the falling phase of the bit clock, and it presents the word with a one-cycle valid strobe. A typical setup runs a 228 MHz input clock with a divisor value of 6, which gives a bit clock of about 33 MHz. A frame period value then sets a frame rate of about 124 kHz, and one 24-bit word is captured per frame.

The divider, period and width settings are sampled when the generator starts and again at each frame boundary. A change made part way through a frame therefore never shortens a frame or a pulse.

Top module: `srg_fsync_gen`

## Requirements
- R1: Each bit period lasts `clk_div`+1 input cycles. `bclk_tick` is high for exactly the first input cycle of each bit period, and `bclk_out` rises in that same cycle.
- R2: Let N = `clk_div`+1. For N ≥ 2, `bclk_out` is high for the first ceil(N/2) cycles of the period and low for the remaining floor(N/2). For N = 1, `bclk_out` stays high and `bclk_tick` is high on every cycle.
- R3: When `en` is sampled high while the generator is idle, the next cycle is the first bit period of a frame, with `bclk_tick` high and frame sync active. A frame lasts `frame_per`+1 bit periods.
- R4: Frame sync is active during bit periods 0 through `frame_wid` of each frame, which is `frame_wid`+1 bit periods, when `frame_wid` < `frame_per`.
- R5: When `frame_wid` ≥ `frame_per`, the pulse is clamped to `frame_per` bit periods, so sync is inactive in the last bit period of the frame. When `frame_per` = 0, sync stays active continuously.
- R6: With `fs_low` = 0, `fs_out` is high while sync is active. With `fs_low` = 1, `fs_out` is inverted, and this includes the idle state, where it reads 1.
- R7: With `samp_fall` = 0, the receive bit of a bit period is taken from `rx_in` in the first cycle of that period. With `samp_fall` = 1 and N ≥ 2, it is taken in the first low cycle of `bclk_out`, which is cycle index ceil(N/2) of the period. For N = 1, both settings sample in the single cycle of the period.
- R8: Bits 0 to `WORD_W`-1 of each frame form `rx_word`, with bit 0 of the frame placed in the MSB. `rx_valid` pulses for one cycle in the cycle after the last bit is sampled. A frame shorter than `WORD_W` bit periods produces no word.
- R9: `clk_div`, `frame_per` and `frame_wid` take effect only at start-up and at a frame boundary. The frame in progress keeps its bit-period length and its sync pattern.
- R10: In reset, and one cycle after `en` is sampled low, `bclk_out`, `bclk_tick` and `rx_valid` are 0 and sync is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops and clears the generator |
| clk_div | input | DIV_W (8) | Bit-clock divisor value; the ratio is value+1 |
| frame_per | input | PER_W (12) | Frame length in bit periods, minus one |
| frame_wid | input | WID_W (8) | Sync pulse width in bit periods, minus one |
| fs_low | input | 1 | 1 selects an active-low `fs_out` |
| samp_fall | input | 1 | 1 selects falling-phase sampling of `rx_in` |
| rx_in | input | 1 | Serial receive data |
| bclk_out | output | 1 | Generated bit clock |
| bclk_tick | output | 1 | One-cycle strobe at the start of each bit period |
| fs_out | output | 1 | Frame sync, with polarity per `fs_low` |
| rx_word | output | WORD_W (24) | Last captured word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |

## Verification
The vector table runs divide ratios of 1, 2, 3, 4, 5, 7 and 256. This separates the pass-through mode, the even-ratio duty split and the odd-ratio duty split, and it finds an off-by-one in the divider. The frame settings cover a normal narrow pulse, a pulse wider than the frame, a width equal to the period, a one-bit frame and the full 4096-bit frame. Together these separate the plain width rule from the clamp and from the continuous-sync case. The serial input carries the correct bit only in the sampling cycle the requirements predict and the inverted bit in every other cycle, so a captured word shows whether the sampling edge was chosen correctly. Directed tests cover changing the divisor and period mid-frame, stopping through the enable, and the reset state.

// File: rtl/srg_fsync_gen.sv
module srg_fsync_gen #(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 12,
  parameter int WID_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [PER_W-1:0]  frame_per,
  input  logic [WID_W-1:0]  frame_wid,
  input  logic              fs_low,
  input  logic              samp_fall,
  input  logic              rx_in,
  output logic              bclk_out,
  output logic              bclk_tick,
  output logic              fs_out,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int CW = (PER_W > WID_W) ? PER_W : WID_W;
  localparam logic [PER_W-1:0] LAST_BIT = PER_W'(WORD_W - 1);

  logic              run;
  logic [DIV_W-1:0]  cnt, div_l;
  logic [PER_W-1:0]  fcnt, per_l, pos;
  logic [WID_W-1:0]  wid_l;
  logic [DIV_W:0]    hi_len;
  logic              bit_end, frame_end, fs_act, samp;
  logic [WORD_W-2:0] sh;

  assign hi_len    = ({1'b0, div_l} + (DIV_W+1)'(2)) >> 1;
  assign bit_end   = run && (cnt == div_l);
  assign frame_end = bit_end && (fcnt == '0);
  assign pos       = per_l - fcnt;

  assign bclk_out  = run && ({1'b0, cnt} < hi_len);
  assign bclk_tick = run && (cnt == '0);
  assign samp      = run && ((samp_fall && (div_l != '0)) ? ({1'b0, cnt} == hi_len)
                                                          : (cnt == '0));
  assign fs_act    = run && ((per_l == '0) ||
                             ((pos < per_l) && (CW'(pos) <= CW'(wid_l))));
  assign fs_out    = fs_act ^ fs_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      fcnt  <= '0;
      div_l <= '0;
      per_l <= '0;
      wid_l <= '0;
    end else if (!en) begin
      run  <= 1'b0;
      cnt  <= '0;
      fcnt <= '0;
    end else if (!run || frame_end) begin
      run   <= 1'b1;
      cnt   <= '0;
      div_l <= clk_div;
      per_l <= frame_per;
      wid_l <= frame_wid;
      fcnt  <= frame_per;
    end else begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
      if (bit_end) fcnt <= fcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (en && samp) begin
        if (pos < LAST_BIT) begin
          sh <= {sh[WORD_W-3:0], rx_in};
        end else if (pos == LAST_BIT) begin
          rx_word  <= {sh, rx_in};
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

module srg_fsync_gen_chk #(
  parameter int DIV_W = 8,
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             run,
  input logic             bclk_out,
  input logic             bclk_tick,
  input logic             fs_out,
  input logic             fs_low,
  input logic             rx_valid,
  input logic             samp,
  input logic             frame_end,
  input logic [DIV_W-1:0] div_l,
  input logic [PER_W-1:0] per_l,
  input logic [WID_W-1:0] wid_l
);

  assert_tick_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> bclk_out);

  assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_out) |-> bclk_tick);

  assert_start_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run) |=> (bclk_tick && (fs_out != fs_low)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_out && !bclk_tick && !rx_valid));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && !frame_end) |=> ($stable(div_l) && $stable(per_l) && $stable(wid_l)));

  assert_valid_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(samp && en));

endmodule

bind srg_fsync_gen srg_fsync_gen_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .bclk_out(bclk_out),
  .bclk_tick(bclk_tick), .fs_out(fs_out), .fs_low(fs_low), .rx_valid(rx_valid),
  .samp(samp), .frame_end(frame_end), .div_l(div_l), .per_l(per_l), .wid_l(wid_l)
);

// File: tb/srg_fsync_gen_test.sv
module srg_fsync_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic        fs_low = 1'b0, samp_fall = 1'b0, rx_in = 1'b0;
  logic [7:0]  clk_div = '0;
  logic [11:0] frame_per = '0;
  logic [7:0]  frame_wid = '0;
  logic        bclk_out, bclk_tick, fs_out, rx_valid;
  logic [23:0] rx_word;

  int checks = 0, fails = 0;

  // div[53:46] per[45:34] wid[33:26] fs_low[25] samp_fall[24] pattern[23:0]
  localparam logic [53:0] VEC [9] = '{
    {8'd6,   12'd31,   8'd0,  1'b0, 1'b1, 24'hA5C39E},
    {8'd0,   12'd23,   8'd2,  1'b0, 1'b0, 24'h123456},
    {8'd1,   12'd25,   8'd3,  1'b1, 1'b1, 24'hFEDCBA},
    {8'd2,   12'd40,   8'd7,  1'b0, 1'b0, 24'h800001},
    {8'd4,   12'd10,   8'd20, 1'b0, 1'b1, 24'h000000},
    {8'd255, 12'd23,   8'd0,  1'b0, 1'b1, 24'h5A5A5A},
    {8'd0,   12'd4095, 8'd0,  1'b0, 1'b0, 24'hC0FFEE},
    {8'd3,   12'd0,    8'd0,  1'b0, 1'b0, 24'h000000},
    {8'd5,   12'd5,    8'd5,  1'b0, 1'b1, 24'h3C3C3C}
  };

  srg_fsync_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_div(clk_div), .frame_per(frame_per),
    .frame_wid(frame_wid), .fs_low(fs_low), .samp_fall(samp_fall), .rx_in(rx_in),
    .bclk_out(bclk_out), .bclk_tick(bclk_tick), .fs_out(fs_out),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [53:0] v);
    int d, n, p, w, sk, lim, nt, ti, k, t0, t1, hi, fscnt, cb, eb;
    bit act, act0, actp1, gotv;
    logic [23:0] pat, gw;
    d = int'(v[53:46]); p = int'(v[45:34]); w = int'(v[33:26]); pat = v[23:0];
    n = d + 1;
    sk = (v[24] && n > 1) ? (n + 1) / 2 : 0;
    lim = n * (((p > 26) ? p : 26) + 3) + 4;
    nt = 0; ti = 0; k = 0; t0 = 0; t1 = 0; hi = 0; fscnt = 0; cb = 0;
    act0 = 0; actp1 = 0; gotv = 0; gw = '0;
    @(negedge clk) en = 1'b0;
    clk_div = v[53:46]; frame_per = v[45:34]; frame_wid = v[33:26];
    fs_low = v[25]; samp_fall = v[24];
    @(negedge clk) en = 1'b1;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (bclk_tick) begin
        ti = nt; nt++; k = 0;
        if (nt == 1) t0 = c;
        if (nt == 2) t1 = c;
        act = fs_out ^ fs_low;
        if (ti <= p && act) fscnt++;
        if (ti == 0) act0 = act;
        if (ti == p + 1) actp1 = act;
        cb = ti % (p + 1);
      end else k++;
      if (nt == 1 && bclk_out) hi++;
      if (rx_valid && !gotv) begin gotv = 1; gw = rx_word; end
      eb = (cb < 24) ? int'(pat[23 - cb]) : 0;
      rx_in = (k == sk) ? eb[0] : ~eb[0];
    end
    chk(t1 - t0 == n, "R1 bit period", t1 - t0, n);
    chk(hi == ((n == 1) ? 1 : (n + 1) / 2), "R2 high phase", hi, (n == 1) ? 1 : (n + 1) / 2);
    chk(act0 && actp1, "R3 frame start and length", {act0, actp1}, 3);
    chk(fscnt == ((p == 0) ? 1 : ((w < p) ? w + 1 : p)), "R4 R5 sync width",
        fscnt, (p == 0) ? 1 : ((w < p) ? w + 1 : p));
    if (p + 1 >= 24) chk(gotv && gw == pat, "R7 R8 captured word", gw, pat);
    else             chk(!gotv, "R8 no word in short frame", gotv, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int tt [40];
    bit aa [40];
    int nt;
    // R10 reset state, R6 idle polarity
    fs_low = 1'b1;
    #(CLK_PERIOD * 2 + 1);
    chk(!bclk_out && !bclk_tick && !rx_valid && rx_word == 0, "R10 reset outputs",
        {bclk_out, bclk_tick, rx_valid}, 0);
    chk(fs_out == 1'b1, "R6 idle active-low sync", fs_out, 1);
    @(negedge clk) fs_low = 1'b0;
    #1 chk(fs_out == 1'b0, "R6 idle active-high sync", fs_out, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) run_vec(VEC[i]);

    // R9 mid-frame change of divisor and period
    @(negedge clk) en = 1'b0;
    clk_div = 8'd1; frame_per = 12'd9; frame_wid = 8'd0; fs_low = 1'b0; samp_fall = 1'b0;
    @(negedge clk) en = 1'b1;
    nt = 0;
    for (int c = 0; c < 250 && nt < 32; c++) begin
      @(negedge clk);
      if (bclk_tick) begin
        tt[nt] = c; aa[nt] = fs_out;
        if (nt == 3) begin clk_div = 8'd3; frame_per = 12'd19; end
        nt++;
      end
    end
    chk(tt[9] - tt[8] == 2, "R9 old divisor kept in frame", tt[9] - tt[8], 2);
    chk(tt[13] - tt[12] == 4, "R9 new divisor after boundary", tt[13] - tt[12], 4);
    chk(aa[10] == 1'b1, "R9 old period kept", aa[10], 1);
    chk(aa[20] == 1'b0, "R9 no early frame", aa[20], 0);
    chk(aa[29] == 1'b0 && aa[30] == 1'b1, "R9 new period", {aa[29], aa[30]}, 1);

    // R10 stop through enable
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk(!bclk_out && !bclk_tick && !fs_out && !rx_valid, "R10 stopped outputs",
        {bclk_out, bclk_tick, fs_out, rx_valid}, 0);
    repeat (5) @(negedge clk);
    chk(!bclk_out && !bclk_tick, "R10 stays idle", {bclk_out, bclk_tick}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule